// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt sources and presents one interrupt request to a processor, together with the number and priority level of the winning source. Software uses a small register bus to program it. Each source has a 4-bit priority. Each source also has an enable bit, which software changes only through separate write-one-to-set and write-one-to-clear addresses, so no read-modify-write is needed. A single control bit decides whether the four lowest-numbered sources, which are the external lines, take part in arbitration. Software can also read the raw source levels and the masked pending requests.

Arbitration is purely combinational over the current enables, priorities and input levels. A balanced comparison tree finds the highest non-zero priority and breaks ties in favour of the lowest source number. The result is registered once before it leaves the block. The asynchronous active-low reset is released synchronously inside the block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all enables, all priority fields and the mode bit are 0, `irq_req` is low, and every register reads as 0 while the inputs are low.
- R2: A write to the enable-set word of bank b (0x70 for sources 0..31, 0x78 for sources 32..63, source s at bit s mod 32) sets every enable whose data bit is 1 and leaves the others unchanged. Reading either enable word of a bank returns that bank's enables.
- R3: A write to the enable-clear word of bank b (0x80, 0x88) clears every enable whose data bit is 1. Writing all ones to both clear words masks every source.
- R4: Priority word k sits at 0x10 + 8*k for k = 0..7. Source i uses bits [4*(i%8)+3 : 4*(i%8)] of word i/8. Priority words read back as written.
- R5: Writing 1 in data bit 0 to 0x00 sets the mode bit, and writing 1 in data bit 0 to 0x08 clears it. A 0 in data bit 0 leaves the mode bit unchanged. Bit 0 of both words reads back the mode bit.
- R6: While the mode bit is 0, sources 0..3 never win arbitration. While it is 1, they arbitrate like any other source.
- R7: A source whose priority field is 0 never raises `irq_req`, even when it is enabled and its input is high.
- R8: One clock edge after the inputs and registers settle, `irq_req` is high exactly when some eligible source has a non-zero priority. `irq_id` and `irq_level` then give the source with the highest priority. With no request, both are 0.
- R9: When several eligible sources share the highest priority, the lowest-numbered one is reported.
- R10: The source-status words (0x50, 0x58) return the raw input levels. The request-status words (0x60, 0x68) return the inputs ANDed with the enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address; words are 8 bytes apart |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_src | input | 64 | Level-sensitive source inputs |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_id | output | 6 | Number of the winning source |
| irq_level | output | 4 | Priority level of the winning source |

## Verification
The hardest situation to reach is a contest between several candidates that differ in only one eligibility condition. Examples are an enabled, pending source with priority 0 sitting beside a real winner, an external line with the top priority while the mode bit is clear, and two sources that tie on priority. The stimulus builds these up one step at a time. Priorities are programmed first. Enables are then added word by word, and input levels are raised one by one. Each step pushes its expected winner into the scoreboard, so every change of eligibility is checked on its own. The mode bit is then toggled with the other candidates held fixed, and finally both clear words mask everything.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  // Word indices (byte address / 8) of the register map.
  localparam int W_CTRL_SET = 0;
  localparam int W_CTRL_CLR = 1;
  localparam int W_PRIO     = 2;
  localparam int W_SRC_STAT = 10;
  localparam int W_REQ_STAT = 12;
  localparam int W_EN_SET   = 14;
  localparam int W_EN_CLR   = 16;

  // Bit of the control word holding the external-line mode.
  localparam int CTRL_MODE_BIT = 0;

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [NUM_SRC-1:0]        src,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_SRC-1:0]        en,
  output logic [NUM_SRC*PRIO_W-1:0] prio,
  output logic                      mode
);

  localparam int NUM_BANK  = NUM_SRC / DATA_W;
  localparam int FLD_PER_W = DATA_W / PRIO_W;
  localparam int NUM_PREG  = NUM_SRC / FLD_PER_W;
  localparam int WORD_W    = ADDR_W - 3;

  logic [WORD_W-1:0] word;
  logic              aligned;
  assign word    = addr[ADDR_W-1:3];
  assign aligned = (addr[2:0] == 3'b000);

  // Decode
  logic ctrl_set_hit, ctrl_clr_hit;
  assign ctrl_set_hit = wr && aligned && (word == WORD_W'(W_CTRL_SET));
  assign ctrl_clr_hit = wr && aligned && (word == WORD_W'(W_CTRL_CLR));

  logic [NUM_PREG-1:0] prio_we;
  logic [NUM_BANK-1:0] en_set_hit, en_clr_hit;

  for (genvar p = 0; p < NUM_PREG; p++) begin : g_prio_dec
    assign prio_we[p] = wr && aligned && (word == WORD_W'(W_PRIO + p));
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_en_dec
    assign en_set_hit[b] = wr && aligned && (word == WORD_W'(W_EN_SET + b));
    assign en_clr_hit[b] = wr && aligned && (word == WORD_W'(W_EN_CLR + b));
  end

  // State
  logic                            mode_q, mode_d, mode_we;
  logic [NUM_BANK-1:0][DATA_W-1:0] en_q, en_d;
  logic [NUM_BANK-1:0]             en_we;
  logic [DATA_W-1:0]               prio_q [NUM_PREG];

  // Next state
  always_comb begin
    mode_we = (ctrl_set_hit || ctrl_clr_hit) && wdata[CTRL_MODE_BIT];
    mode_d  = ctrl_set_hit;
  end

  always_comb begin
    for (int b = 0; b < NUM_BANK; b++) begin
      en_we[b] = en_set_hit[b] || en_clr_hit[b];
      if (en_set_hit[b]) en_d[b] = en_q[b] | wdata;
      else               en_d[b] = en_q[b] & ~wdata;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (mode_we) begin
      mode_q <= mode_d;
    end
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_en_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[b] <= '0;
      end else if (en_we[b]) begin
        en_q[b] <= en_d[b];
      end
    end
  end

  for (genvar p = 0; p < NUM_PREG; p++) begin : g_prio_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[p] <= '0;
      end else if (prio_we[p]) begin
        prio_q[p] <= wdata;
      end
    end
    assign prio[p*DATA_W +: DATA_W] = prio_q[p];
  end

  assign en   = en_q;
  assign mode = mode_q;

  // Read mux
  always_comb begin
    rdata = '0;
    if (aligned) begin
      if (word == WORD_W'(W_CTRL_SET) || word == WORD_W'(W_CTRL_CLR)) begin
        rdata[CTRL_MODE_BIT] = mode_q;
      end
      for (int p = 0; p < NUM_PREG; p++) begin
        if (word == WORD_W'(W_PRIO + p)) rdata = prio_q[p];
      end
      for (int b = 0; b < NUM_BANK; b++) begin
        if (word == WORD_W'(W_SRC_STAT + b)) rdata = src[b*DATA_W +: DATA_W];
        if (word == WORD_W'(W_REQ_STAT + b)) rdata = src[b*DATA_W +: DATA_W] & en_q[b];
        if (word == WORD_W'(W_EN_SET + b) || word == WORD_W'(W_EN_CLR + b)) rdata = en_q[b];
      end
    end
  end

  // Assertions
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_en_chk
    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en_set_hit[b] |=> ((en_q[b] & $past(wdata)) == $past(wdata)));
    p_en_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en_set_hit[b] |=> ((en_q[b] & ~$past(wdata)) == ($past(en_q[b]) & ~$past(wdata))));
    p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr_hit[b] |=> ((en_q[b] & $past(wdata)) == '0));
  end

  p_mode_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_set_hit && wdata[CTRL_MODE_BIT]) |=> mode_q);
  p_mode_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_clr_hit && wdata[CTRL_MODE_BIT]) |=> !mode_q);
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !((ctrl_set_hit || ctrl_clr_hit) && wdata[CTRL_MODE_BIT]) |=> $stable(mode_q));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC*PRIO_W-1:0] lvl_in,
  output logic [PRIO_W-1:0]         win_lvl,
  output logic [ID_W-1:0]           win_id
);

  localparam int LVLS = $clog2(NUM_SRC);

  // Level LVLS holds the leaves, level 0 the root. A right child wins
  // only on a strictly higher level, so ties go to lower numbers.
  for (genvar l = LVLS; l >= 0; l--) begin : g_lvl
    logic [PRIO_W-1:0] lv  [2**l];
    logic [ID_W-1:0]   idv [2**l];
    for (genvar n = 0; n < 2**l; n++) begin : g_node
      if (l == LVLS) begin : g_leaf
        assign lv[n]  = lvl_in[n*PRIO_W +: PRIO_W];
        assign idv[n] = ID_W'(n);
      end else begin : g_cmp
        logic pick_r;
        assign pick_r = g_lvl[l+1].lv[2*n+1] > g_lvl[l+1].lv[2*n];
        assign lv[n]  = pick_r ? g_lvl[l+1].lv[2*n+1]  : g_lvl[l+1].lv[2*n];
        assign idv[n] = pick_r ? g_lvl[l+1].idv[2*n+1] : g_lvl[l+1].idv[2*n];
      end
    end
  end

  assign win_lvl = g_lvl[0].lv[0];
  assign win_id  = g_lvl[0].idv[0];

  // Assertions: the winner is maximal and lowest-numbered among equals.
  logic above_seen, tie_below;
  always_comb begin
    above_seen = 1'b0;
    tie_below  = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (lvl_in[i*PRIO_W +: PRIO_W] > win_lvl) above_seen = 1'b1;
      if ((win_lvl != '0) && (ID_W'(i) < win_id) &&
          (lvl_in[i*PRIO_W +: PRIO_W] == win_lvl)) tie_below = 1'b1;
    end
    p_winner_max_r8: assert (!above_seen);
    p_tie_lowest_r9: assert (!tie_below);
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int NUM_EXT = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic               irq_req,
  output logic [ID_W-1:0]    irq_id,
  output logic [PRIO_W-1:0]  irq_level
);

  localparam logic [NUM_SRC-1:0] ONE_HOT0 = NUM_SRC'(1);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_SRC-1:0]        en;
  logic [NUM_SRC*PRIO_W-1:0] prio;
  logic                      mode;

  irq_regfile #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) regs_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .src   (irq_src),
    .rdata (bus_rdata),
    .en    (en),
    .prio  (prio),
    .mode  (mode)
  );

  // Masking: enable, pending, and external lines only in mode 1
  logic [NUM_SRC-1:0]        elig;
  logic [NUM_SRC*PRIO_W-1:0] cand_lvl;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
    if (i < NUM_EXT) begin : g_ext
      assign elig[i] = irq_src[i] && en[i] && mode;
    end else begin : g_int
      assign elig[i] = irq_src[i] && en[i];
    end
    assign cand_lvl[i*PRIO_W +: PRIO_W] = elig[i] ? prio[i*PRIO_W +: PRIO_W] : '0;
  end

  logic [PRIO_W-1:0] win_lvl;
  logic [ID_W-1:0]   win_id;

  irq_arbiter #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .ID_W    (ID_W)
  ) arb_i (
    .lvl_in  (cand_lvl),
    .win_lvl (win_lvl),
    .win_id  (win_id)
  );

  // Output stage
  logic              req_q, req_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [PRIO_W-1:0] lvl_q, lvl_d;

  always_comb begin
    req_d = (win_lvl != '0);
    id_d  = req_d ? win_id : '0;
    lvl_d = win_lvl;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q <= 1'b0;
      id_q  <= '0;
      lvl_q <= '0;
    end else begin
      req_q <= req_d;
      id_q  <= id_d;
      lvl_q <= lvl_d;
    end
  end

  assign irq_req   = req_q;
  assign irq_id    = id_q;
  assign irq_level = lvl_q;

  // Assertions
  p_req_level_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req |-> (irq_level != '0));
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !irq_req |-> (irq_id == '0 && irq_level == '0));
  p_winner_elig_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req |-> (($past(elig) & (ONE_HOT0 << irq_id)) != '0));
  p_ext_masked_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_req && !$past(mode)) |-> (irq_id >= ID_W'(NUM_EXT)));

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

  typedef struct packed {
    logic       req;
    logic [5:0] id;
    logic [3:0] lvl;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_src = '0;
  logic        irq_req;
  logic [5:0]  irq_id;
  logic [3:0]  irq_level;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_src   (irq_src),
    .irq_req   (irq_req),
    .irq_id    (irq_id),
    .irq_level (irq_level)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: compare registered outputs after each edge with queued items
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() != 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'({irq_req, irq_id, irq_level}), 32'(e));
      end
    end
  end

  task automatic push(string tag, logic req, logic [5:0] id, logic [3:0] lvl);
    exp_t e;
    e.req = req; e.id = id; e.lvl = lvl;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(string tag, logic [7:0] a, logic [31:0] expv);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, expv);
  endtask

  task automatic set_src(int s, logic v);
    @(negedge clk);
    irq_src[s] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 req", 32'(irq_req), 32'h0);
    bus_read("R1 ctrl", 8'h00, 32'h0);
    bus_read("R1 prio", 8'h10, 32'h0);
    bus_read("R1 en", 8'h70, 32'h0);
    bus_read("R1 reqstat", 8'h60, 32'h0);

    // R4: priority layout (src2=F, src12=5, src20=5, src40=3, src50=9)
    bus_write(8'h10, 32'h0000_0F00);
    bus_write(8'h18, 32'h0005_0000);
    bus_write(8'h20, 32'h0005_0000);
    bus_write(8'h38, 32'h0000_0003);
    bus_write(8'h40, 32'h0000_0900);
    bus_read("R4 prio5", 8'h38, 32'h0000_0003);
    bus_read("R4 prio1", 8'h18, 32'h0005_0000);

    // R2: set keeps other bits; R3: clear
    bus_write(8'h70, 32'h5);
    bus_write(8'h70, 32'h2);
    bus_read("R2 set keep", 8'h70, 32'h7);
    bus_write(8'h80, 32'h7);
    bus_read("R3 clear", 8'h80, 32'h0);
    bus_write(8'h78, 32'h0000_0100);
    bus_read("R2 bank1", 8'h78, 32'h0000_0100);

    // R8: single winner
    set_src(40, 1'b1); push("R8 single", 1'b1, 6'd40, 4'd3);
    // R7: enabled pending priority-0 source does not win
    bus_write(8'h70, 32'h0000_0400);
    set_src(10, 1'b1); push("R7 zero-prio beside", 1'b1, 6'd40, 4'd3);
    bus_write(8'h88, 32'h0000_0100); push("R7 zero-prio alone", 1'b0, 6'd0, 4'd0);

    // R9: tie goes to lowest number
    bus_write(8'h70, 32'h0010_1000);
    set_src(20, 1'b1); push("R8 src20", 1'b1, 6'd20, 4'd5);
    set_src(12, 1'b1); push("R9 tie", 1'b1, 6'd12, 4'd5);

    // R8: higher priority in bank 1
    bus_write(8'h78, 32'h0004_0000);
    set_src(50, 1'b1); push("R8 higher", 1'b1, 6'd50, 4'd9);

    // R6: external line masked in mode 0
    bus_write(8'h70, 32'h0000_0004);
    set_src(2, 1'b1); push("R6 mode0 masked", 1'b1, 6'd50, 4'd9);
    bus_write(8'h00, 32'h1); push("R6 mode1 wins", 1'b1, 6'd2, 4'd15);
    bus_read("R5 read clr word", 8'h08, 32'h1);
    bus_write(8'h08, 32'h0); push("R5 zero no effect", 1'b1, 6'd2, 4'd15);
    bus_read("R5 still set", 8'h00, 32'h1);

    // R10: status words
    set_src(63, 1'b1);
    bus_read("R10 src0", 8'h50, 32'h0010_1404);
    bus_read("R10 src1", 8'h58, 32'h8004_0100);
    bus_read("R10 req0", 8'h60, 32'h0010_1404);
    bus_read("R10 req1", 8'h68, 32'h0004_0000);

    // R5: clear mode
    bus_write(8'h08, 32'h1); push("R5 mode clr", 1'b1, 6'd50, 4'd9);
    bus_read("R5 mode 0", 8'h00, 32'h0);

    // R3: all-ones clear masks everything
    bus_write(8'h80, 32'hFFFF_FFFF); push("R3 bank0 masked", 1'b1, 6'd50, 4'd9);
    bus_write(8'h88, 32'hFFFF_FFFF); push("R3 all masked", 1'b0, 6'd0, 4'd0);
    bus_read("R3 en0", 8'h70, 32'h0);
    bus_read("R3 en1", 8'h78, 32'h0);
    bus_read("R10 req0 masked", 8'h60, 32'h0);

    repeat (4) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule